// File: doc/BRIEF.md
# Double-Buffered Handshake Input Port

This block is an input port with a parameterised width (8 bits by default) that sits between a peripheral and a bus register interface. The peripheral places a byte on the data pins and pulses a strobe pin. Each accepted strobe edge loads the byte into a two-entry latch path. The bus side reads the oldest byte through a read-data port. Each read strobe retires one entry. A status output shows whether any unread byte is waiting.

A ready pin goes back to the peripheral. It tells the peripheral when the latches can take another byte. The ready pin runs one of two protocols. In the interlocked protocol it stays asserted for as long as there is room. In the pulsed protocol it gives a pulse of at most four clocks. An enable input holds the ready pin negated. Two sense inputs set the active level of the strobe pin and of the ready pin.

The ready pin is driven by a five-state machine. RS_OFF: disabled, ready negated. RS_WAIT: negated, waiting for room after a strobe. RS_READY: asserted, interlocked. RS_PULSE: asserted, pulse running. RS_SPENT: pulse over, negated until the next strobe. The transitions are:
- Any state goes to RS_OFF when the enable input is low.
- RS_OFF goes to RS_WAIT when enabled.
- RS_WAIT goes to RS_READY (interlocked) or RS_PULSE (pulsed) when there is room and no strobe edge in that cycle.
- RS_READY, RS_PULSE and RS_SPENT go to RS_WAIT on a strobe edge.
- RS_PULSE goes to RS_SPENT after its fourth cycle.

Top module: `hs_in_port`

## Requirements
- R1: A strobe edge that is accepted stores the value of `pin_data` in the cycle the edge is detected. `bus_rdata` always presents the oldest unread byte. A cycle with `bus_rd` high retires that byte, so bytes leave in arrival order.
- R2: `stat_avail` is 1 exactly when at least one unread byte is held. A strobe edge is detected and takes effect at the third rising clock edge after the strobe pin changes.
- R3: In interlocked mode (`cfg_mode` = 0), the ready pin is asserted whenever there is room and the machine has settled in RS_READY. It is negated in the clock after an accepted strobe edge. It is asserted again one clock later if room remains.
- R4: With both latches full, the ready pin stays negated and further strobe edges are ignored until a read frees an entry.
- R5: In pulsed mode (`cfg_mode` = 1), the ready pin asserts under the same condition as in R3. It stays asserted for exactly 4 clocks and then stays negated until the next strobe edge.
- R6: In pulsed mode, a strobe edge detected while the pulse is running ends the pulse early, in the next clock.
- R7: While `cfg_en` = 0, the ready pin is held negated.
- R8: `cfg_sense_stb` = 0 makes the strobe active low, and 1 makes it active high. `cfg_sense_rdy` = 0 drives the ready pin low when asserted, and 1 drives it high when asserted.
- R9: `stat_rdy` (the ready-pin status bit) always reads 0.
- R10: After reset, both latches are empty, `stat_avail` is 0 and the ready pin is negated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_en | input | 1 | Enables the ready pin; 0 holds it negated |
| cfg_mode | input | 1 | Ready protocol: 0 interlocked, 1 pulsed |
| cfg_sense_stb | input | 1 | Strobe polarity: 0 active low, 1 active high |
| cfg_sense_rdy | input | 1 | Ready polarity: 0 low when asserted, 1 high when asserted |
| pin_data | input | DATA_W | Parallel data from the peripheral |
| pin_stb | input | 1 | Strobe from the peripheral |
| pin_rdy | output | 1 | Ready handshake to the peripheral |
| bus_rd | input | 1 | Data-register read strobe; retires the oldest byte |
| bus_rdata | output | DATA_W | Oldest unread byte |
| stat_avail | output | 1 | Unread data present |
| stat_rdy | output | 1 | Ready-pin status bit, constant 0 |

## Verification
A change on the strobe pin shows up in `stat_avail`, `bus_rdata` and the ready state machine at the third rising edge after it: two synchroniser stages, then the edge register. The ready pin settles one clock after that. A read strobe that is high at a rising edge updates `bus_rdata` and `stat_avail` at that same edge. A pulse starts one edge after room appears. The bench updates a behavioural model at every rising edge from the inputs it drove at the falling edge before. It compares all outputs at the next falling edge, so every expected value is sampled half a period after the edge that produces it. The directed checks count asserted ready cycles over windows longer than the pulse, so the pulse length and early cuts are measured and not assumed.

// File: rtl/hs_in_pkg.sv
package hs_in_pkg;

    typedef enum logic [2:0] {
        RS_OFF,
        RS_WAIT,
        RS_READY,
        RS_PULSE,
        RS_SPENT
    } rdy_state_e;

    typedef enum logic {
        HS_INTERLOCK = 1'b0,
        HS_PULSED    = 1'b1
    } hs_mode_e;

endpackage

// File: rtl/hs_sync_edge.sv
module hs_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic sense,
    output logic edge_o
);
    localparam int LAST = STAGES - 1;

    logic             raw_act;
    logic [LAST:0]    chain_q;
    logic             prev_q;

    // Active level after polarity: sense 0 means low is active.
    assign raw_act = ~(pin ^ sense);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q[0] <= 1'b0;
        end else begin
            chain_q[0] <= raw_act;
        end
    end

    generate
        for (genvar g = 1; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain_q[g] <= 1'b0;
                end else begin
                    chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= chain_q[LAST];
        end
    end

    assign edge_o = chain_q[LAST] & ~prev_q;

endmodule

// File: rtl/hs_latch_pair.sv
module hs_latch_pair #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic [1:0]        fill
);
    localparam logic [1:0] FULL = 2'd2;

    logic [DATA_W-1:0] ent0_q, ent1_q;
    logic [1:0]        fill_q;
    logic              push_ok, pop_ok;

    assign push_ok = push && (fill_q != FULL);
    assign pop_ok  = pop && (fill_q != 2'd0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ent0_q <= '0;
            ent1_q <= '0;
            fill_q <= 2'd0;
        end else begin
            unique case ({push_ok, pop_ok})
                2'b01: begin
                    ent0_q <= ent1_q;
                    fill_q <= fill_q - 2'd1;
                end
                2'b10: begin
                    if (fill_q == 2'd0) ent0_q <= push_data;
                    else                ent1_q <= push_data;
                    fill_q <= fill_q + 2'd1;
                end
                2'b11: begin
                    // only possible with one entry held
                    ent0_q <= push_data;
                end
                default: begin
                end
            endcase
        end
    end

    assign head = ent0_q;
    assign fill = fill_q;

endmodule

// File: rtl/hs_rdy_fsm.sv
module hs_rdy_fsm
    import hs_in_pkg::*;
#(
    parameter int PULSE_LEN = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     en,
    input  hs_mode_e mode,
    input  logic     stb_edge,
    input  logic     room,
    output logic     rdy_on
);
    localparam int             CW   = $clog2(PULSE_LEN + 1);
    localparam logic [CW-1:0]  LAST = CW'(PULSE_LEN - 1);

    rdy_state_e     state_q, state_d;
    logic [CW-1:0]  pcnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RS_OFF;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   pcnt_q <= '0;
        else if (state_q == RS_PULSE) pcnt_q <= pcnt_q + 1'b1;
        else                          pcnt_q <= '0;
    end

    always_comb begin
        state_d = state_q;
        if (!en) begin
            state_d = RS_OFF;
        end else begin
            unique case (state_q)
                RS_OFF:   state_d = RS_WAIT;
                RS_WAIT:  if (room && !stb_edge)
                              state_d = (mode == HS_PULSED) ? RS_PULSE : RS_READY;
                RS_READY: if (stb_edge) state_d = RS_WAIT;
                RS_PULSE: if (stb_edge)            state_d = RS_WAIT;
                          else if (pcnt_q == LAST) state_d = RS_SPENT;
                RS_SPENT: if (stb_edge) state_d = RS_WAIT;
                default:  state_d = RS_OFF;
            endcase
        end
    end

    always_comb begin
        rdy_on = (state_q == RS_READY) || (state_q == RS_PULSE);
    end

endmodule

// File: rtl/hs_in_port.sv
module hs_in_port
    import hs_in_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int PULSE_LEN   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_en,
    input  logic              cfg_mode,
    input  logic              cfg_sense_stb,
    input  logic              cfg_sense_rdy,
    input  logic [DATA_W-1:0] pin_data,
    input  logic              pin_stb,
    output logic              pin_rdy,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              stat_avail,
    output logic              stat_rdy
);
    logic       stb_edge;
    logic [1:0] fill_lvl;
    logic       room;
    logic       rdy_on;

    hs_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin    (pin_stb),
        .sense  (cfg_sense_stb),
        .edge_o (stb_edge)
    );

    hs_latch_pair #(.DATA_W(DATA_W)) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (stb_edge),
        .push_data (pin_data),
        .pop       (bus_rd),
        .head      (bus_rdata),
        .fill      (fill_lvl)
    );

    assign room = (fill_lvl != 2'd2);

    hs_rdy_fsm #(.PULSE_LEN(PULSE_LEN)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (cfg_en),
        .mode     (hs_mode_e'(cfg_mode)),
        .stb_edge (stb_edge),
        .room     (room),
        .rdy_on   (rdy_on)
    );

    assign pin_rdy    = ~(rdy_on ^ cfg_sense_rdy);
    assign stat_avail = (fill_lvl != 2'd0);
    assign stat_rdy   = 1'b0;

endmodule

// File: rtl/hs_in_port_chk.sv
module hs_in_port_chk #(
    parameter int PULSE_LEN = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_en,
    input logic       cfg_mode,
    input logic       stb_edge,
    input logic       rdy_on,
    input logic [1:0] fill,
    input logic       stat_avail
);
    int run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  run_q <= 0;
        else if (rdy_on && cfg_mode) run_q <= run_q + 1;
        else                         run_q <= 0;
    end

    // R7
    rdy_off_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> !rdy_on);

    // R4
    no_ready_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill == 2'd2) |-> !rdy_on);

    // R3
    rdy_drop_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_edge && cfg_en) |=> !rdy_on);

    // R5
    pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_on && cfg_mode) |-> (run_q < PULSE_LEN));

    // R2
    avail_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_avail) |-> $past(stb_edge));

endmodule

bind hs_in_port hs_in_port_chk #(.PULSE_LEN(PULSE_LEN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_en     (cfg_en),
    .cfg_mode   (cfg_mode),
    .stb_edge   (stb_edge),
    .rdy_on     (rdy_on),
    .fill       (fill_lvl),
    .stat_avail (stat_avail)
);

// File: tb/test_hs_in_port.sv
module test_hs_in_port;
    localparam int PL = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_en = 1'b0, cfg_mode = 1'b0, sns_s = 1'b0, sns_r = 1'b0;
    logic pin_stb = 1'b1, bus_rd = 1'b0;
    logic [7:0] pin_data = 8'h00;
    logic pin_rdy, stat_avail, stat_rdy;
    logic [7:0] bus_rdata;

    hs_in_port i_hs_in_port (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_mode(cfg_mode),
        .cfg_sense_stb(sns_s), .cfg_sense_rdy(sns_r), .pin_data(pin_data),
        .pin_stb(pin_stb), .pin_rdy(pin_rdy), .bus_rd(bus_rd),
        .bus_rdata(bus_rdata), .stat_avail(stat_avail), .stat_rdy(stat_rdy)
    );

    always #4 clk = ~clk;

    int n_chk = 0, n_err = 0, wd = 0;
    bit done = 1'b0;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // behavioural reference: ph 0 off, 1 wait, 2 ready, 3 pulse, 4 spent
    bit m1, m2, m3;
    int ph, pc;
    int q[$];

    always @(posedge clk) begin
        bit e, rm, pp, acc;
        int sz;
        if (!rst_n) begin
            m1 = 0; m2 = 0; m3 = 0; ph = 0; pc = 0; q.delete();
        end else begin
            sz  = q.size();
            e   = m2 & ~m3;
            rm  = sz < 2;
            pp  = bus_rd && sz > 0;
            acc = e && sz < 2;
            if (!cfg_en) ph = 0;
            else case (ph)
                0: ph = 1;
                1: if (rm && !e) begin ph = cfg_mode ? 3 : 2; pc = 0; end
                2: if (e) ph = 1;
                3: if (e) ph = 1; else if (pc == PL-1) ph = 4; else pc++;
                default: if (e) ph = 1;
            endcase
            if (pp)  void'(q.pop_front());
            if (acc) q.push_back(int'(pin_data));
            m3 = m2; m2 = m1; m1 = (pin_stb == sns_s);
        end
    end

    always @(negedge clk) begin
        bit on;
        if (rst_n && !done) begin
            chk(stat_avail == (q.size() > 0), "R2", "avail", stat_avail, q.size() > 0);
            if (q.size() > 0) chk(int'(bus_rdata) == q[0], "R1", "rdata", bus_rdata, q[0]);
            on = (ph == 2) || (ph == 3);
            chk(pin_rdy == (on ? sns_r : !sns_r), "R3/R5/R6/R7/R8", "ready pin",
                pin_rdy, on ? sns_r : !sns_r);
            chk(stat_rdy == 1'b0, "R9", "ready status", stat_rdy, 0);
        end
    end

    always @(posedge clk) begin
        wd++;
        if (wd > 50000 && !done) begin
            done = 1'b1;
            n_chk++; n_err++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic strobe(input logic [7:0] d, input int hi, input int lo);
        @(negedge clk);
        pin_data = d; pin_stb = sns_s;
        cyc(hi);
        pin_stb = !sns_s;
        cyc(lo);
    endtask

    task automatic read_chk(input logic [7:0] exp, input string req);
        @(negedge clk);
        chk(stat_avail && bus_rdata == exp, req, "read byte", bus_rdata, exp);
        bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic count_on(input int n, output int c);
        c = 0;
        repeat (n) begin
            @(negedge clk);
            if (pin_rdy == sns_r) c++;
        end
    endtask

    task automatic do_reset(input logic ss, input logic sr);
        @(negedge clk);
        rst_n = 1'b0; sns_s = ss; sns_r = sr; pin_stb = !ss;
        cyc(3);
        rst_n = 1'b1;
        @(negedge clk);
        chk(stat_avail == 1'b0, "R10", "avail after reset", stat_avail, 0);
        chk(pin_rdy == !sr, "R10", "ready negated after reset", pin_rdy, !sr);
    endtask

    initial begin
        int c;
        do_reset(1'b0, 1'b0);
        cfg_en = 1'b1; cfg_mode = 1'b0;
        cyc(3);
        chk(pin_rdy == 1'b0, "R3", "ready with room", pin_rdy, 0);

        // fill both latches, third strobe must be dropped
        strobe(8'hA1, 3, 3); strobe(8'hB2, 3, 3); strobe(8'hC3, 3, 3);
        chk(stat_avail == 1'b1, "R2", "avail when full", stat_avail, 1);
        chk(pin_rdy == 1'b1, "R4", "ready negated when full", pin_rdy, 1);
        read_chk(8'hA1, "R1");
        read_chk(8'hB2, "R4");
        @(negedge clk);
        chk(stat_avail == 1'b0, "R4", "strobe while full ignored", stat_avail, 0);

        strobe(8'h5D, 3, 3);
        read_chk(8'h5D, "R3");

        // pulsed protocol
        cfg_en = 1'b0; cyc(2); cfg_mode = 1'b1; cfg_en = 1'b1;
        count_on(12, c);
        chk(c == PL, "R5", "pulse length", c, PL);
        strobe(8'hE5, 3, 3); strobe(8'hF6, 3, 3);
        read_chk(8'hE5, "R1");
        count_on(10, c);
        chk(c == PL, "R5", "pulse after read", c, PL);
        read_chk(8'hF6, "R1");
        cyc(6);

        // early cut by a fast second strobe
        @(negedge clk);
        pin_data = 8'h71; pin_stb = sns_s;
        cyc(2); pin_stb = !sns_s;
        cyc(2); pin_data = 8'h82; pin_stb = sns_s;
        c = 0;
        repeat (12) begin
            @(negedge clk);
            if (pin_rdy == sns_r) c++;
        end
        pin_stb = !sns_s;
        chk(c > 0 && c < PL, "R6", "cut pulse length", c, PL-1);
        read_chk(8'h71, "R6");
        read_chk(8'h82, "R6");

        // disable
        cfg_en = 1'b0;
        count_on(10, c);
        chk(c == 0, "R7", "ready while disabled", c, 0);

        // inverted polarities
        cfg_mode = 1'b0;
        do_reset(1'b1, 1'b1);
        cfg_en = 1'b1;
        cyc(3);
        chk(pin_rdy == 1'b1, "R8", "active-high ready", pin_rdy, 1);
        strobe(8'h3C, 3, 3);
        read_chk(8'h3C, "R8");
        @(negedge clk);
        chk(stat_avail == 1'b0, "R8", "empty after read", stat_avail, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule